// File: doc/BRIEF.md
# Bi-phase Coded Pseudo-Noise Excitation Generator

This block drives a capacitive sensing front end. It produces a spread-spectrum excitation bit stream. A 12-bit linear feedback shift register steps through a maximal-length sequence of 4095 chips. Each chip is split into two half-chips. The coded output equals the chip during the first half and its inverse during the second half. This bi-phase coding moves the energy of the sequence away from DC and limits any run of equal levels to two half-chips.

A counter divides the system clock to produce the half-chip timing. The division ratio is a parameter. For a full sequence to repeat at 10 Hz, the chip rate must be about 40.95 kchip/s. The ratio is therefore chosen as system clock / (2 x 40950).

The outputs are free-running levels, not a handshaked stream. The downstream driver has no way to push back on the generator. The only flow control is the enable input. While enable is low, the waveform is held at its current level and no time passes for the generator.

Top module: `pngen_top`

## Requirements
- R1: While the synchronous reset is high, and after it is released with the enable still low, `pn_chip` equals bit 11 of the seed (0 for the default seed 12'h001), and `chip_phase`, `mcode` and `seq_start` are 0.
- R2: Each half-chip lasts exactly HALF_DIV enabled clock cycles. `chip_phase` is 0 in the first half of a chip and 1 in the second half.
- R3: The shift register state s starts at the seed. It steps to {s[10:0], s[11]^s[5]^s[3]^s[0]} at the end of each chip. `pn_chip` is s[11] and stays constant across both halves of a chip.
- R4: `mcode` equals `pn_chip` XOR `chip_phase`. The two halves of every chip therefore carry opposite levels.
- R5: The chip sequence repeats every 4095 chips. One period holds 2048 ones and 2047 zeros, and the register never settles in the all-zero state (it is reloaded with the seed if that state ever appears).
- R6: `mcode` never keeps one level for more than two consecutive half-chips.
- R7: `seq_start` is high for exactly one clock cycle: the first cycle of a chip whose register state has wrapped back to the seed. It does not pulse for the first sequence after reset.
- R8: While `en` is low, `pn_chip`, `chip_phase` and `mcode` hold their values, and the half-chip timing does not advance.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Advance enable; low freezes the waveform |
| pn_chip | output | 1 | Current raw pseudo-noise chip |
| mcode | output | 1 | Bi-phase coded excitation bit |
| seq_start | output | 1 | One-cycle pulse when the sequence wraps to its seed |
| chip_phase | output | 1 | Half-chip index within the current chip |

## Verification
The hardest event to reach is the sequence wrap. It only occurs after 4095 chips, that is 32760 clocks at the default ratio. The stimulus therefore runs two full periods with the enable held high. Expected half-chip levels are precomputed from the stated recurrence, and `seq_start` must appear on exactly the two wrap cycles and nowhere else. A pause of several cycles is inserted in the middle of a half-chip, to show that a frozen stretch neither shortens that half-chip nor shifts the wrap.

// File: rtl/pngen_pkg.sv
package pngen_pkg;
  localparam int          LFSR_W       = 12;
  // feedback taps at bits 11, 5, 3, 0 (x^12 + x^6 + x^4 + x + 1)
  localparam logic [LFSR_W-1:0] TAP_MASK     = 12'h829;
  localparam logic [LFSR_W-1:0] DEFAULT_SEED = 12'h001;

  function automatic logic [LFSR_W-1:0] lfsr_step(input logic [LFSR_W-1:0] s);
    return {s[LFSR_W-2:0], ^(s & TAP_MASK)};
  endfunction
endpackage

// File: rtl/pngen_divider.sv
module pngen_divider #(
  parameter int HALF_DIV = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic phase,
  output logic chip_end
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt_q;
  logic          half_tick;

  assign half_tick = en && (cnt_q == LAST);
  assign chip_end  = half_tick && phase;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      phase <= 1'b0;
    end else if (en) begin
      cnt_q <= half_tick ? '0 : cnt_q + 1'b1;
      if (half_tick) phase <= ~phase;
    end
  end
endmodule

// File: rtl/pngen_lfsr.sv
module pngen_lfsr
  import pngen_pkg::*;
#(
  parameter logic [LFSR_W-1:0] SEED = DEFAULT_SEED
) (
  input  logic clk,
  input  logic rst,
  input  logic adv,
  output logic chip,
  output logic wrap
);
  logic [LFSR_W-1:0] st_q;
  logic [LFSR_W-1:0] st_nx;

  always_comb begin
    st_nx = lfsr_step(st_q);
    if (st_nx == '0) st_nx = SEED;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= SEED;
      wrap <= 1'b0;
    end else begin
      wrap <= 1'b0;
      if (st_q == '0) begin
        st_q <= SEED;
      end else if (adv) begin
        st_q <= st_nx;
        wrap <= (st_nx == SEED);
      end
    end
  end

  assign chip = st_q[LFSR_W-1];
endmodule

// File: rtl/pngen_coder.sv
module pngen_coder (
  input  logic chip,
  input  logic phase,
  output logic coded
);
  assign coded = chip ^ phase;
endmodule

// File: rtl/pngen_top.sv
module pngen_top
  import pngen_pkg::*;
#(
  parameter int                HALF_DIV = 4,
  parameter logic [LFSR_W-1:0] SEED     = DEFAULT_SEED
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic pn_chip,
  output logic mcode,
  output logic seq_start,
  output logic chip_phase
);
  logic chip_end;

  pngen_divider #(.HALF_DIV(HALF_DIV)) u_div (
    .clk      (clk),
    .rst      (rst),
    .en       (en),
    .phase    (chip_phase),
    .chip_end (chip_end)
  );

  pngen_lfsr #(.SEED(SEED)) u_lfsr (
    .clk  (clk),
    .rst  (rst),
    .adv  (chip_end),
    .chip (pn_chip),
    .wrap (seq_start)
  );

  pngen_coder u_code (
    .chip  (pn_chip),
    .phase (chip_phase),
    .coded (mcode)
  );
endmodule

// File: rtl/pngen_checker.sv
module pngen_checker
  import pngen_pkg::*;
#(
  parameter logic [LFSR_W-1:0] SEED = DEFAULT_SEED
) (
  input logic clk,
  input logic rst,
  input logic en,
  input logic pn_chip,
  input logic mcode,
  input logic seq_start,
  input logic chip_phase
);
  // R4: entering the second half flips the coded level
  a_r4_half_inverts: assert property (@(posedge clk) disable iff (rst)
    $rose(chip_phase) |-> (mcode != $past(mcode)));

  // R3: the raw chip does not change between its two halves
  a_r3_chip_steady: assert property (@(posedge clk) disable iff (rst)
    $rose(chip_phase) |-> $stable(pn_chip));

  // R8: nothing moves while enable is low
  a_r8_freeze: assert property (@(posedge clk) disable iff (rst)
    !en |=> ($stable(pn_chip) && $stable(chip_phase) && $stable(mcode)));

  // R7: start pulse lasts a single cycle
  a_r7_single_pulse: assert property (@(posedge clk) disable iff (rst)
    seq_start |=> !seq_start);

  // R7: start pulse marks the first half of the seed chip
  a_r7_at_seed_chip: assert property (@(posedge clk) disable iff (rst)
    seq_start |-> (!chip_phase && (pn_chip == SEED[LFSR_W-1])));

  // R2: phase can only change when enable was high
  a_r2_phase_needs_en: assert property (@(posedge clk) disable iff (rst)
    (chip_phase != $past(chip_phase)) |-> $past(en));
endmodule

bind pngen_top pngen_checker #(.SEED(SEED)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .en         (en),
  .pn_chip    (pn_chip),
  .mcode      (mcode),
  .seq_start  (seq_start),
  .chip_phase (chip_phase)
);

// File: tb/tb_pngen_top.sv
module tb_pngen_top;
  localparam int          HD    = 4;
  localparam logic [11:0] SEED  = 12'h001;
  localparam int          PER   = 4095;
  localparam int          NCH   = 8200;
  localparam int          PAUSE = 1000 * 2 * HD + 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en  = 1'b0;
  logic pn_chip, mcode, seq_start, chip_phase;

  int  checks = 0;
  int  errors = 0;
  bit  done   = 1'b0;
  logic [1:0] exp_q[$];   // {pn, coded}

  always #2 clk = ~clk;

  pngen_top #(.HALF_DIV(HD), .SEED(SEED)) dut (
    .clk(clk), .rst(rst), .en(en),
    .pn_chip(pn_chip), .mcode(mcode),
    .seq_start(seq_start), .chip_phase(chip_phase)
  );

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // driver: expected half-chips from the R3 recurrence and R4 coding rule
  task automatic push_chips(input int n);
    logic [11:0] s;
    s = SEED;
    for (int i = 0; i < n; i++) begin
      exp_q.push_back({s[11], s[11]});
      exp_q.push_back({s[11], ~s[11]});
      s = {s[10:0], s[11] ^ s[5] ^ s[3] ^ s[0]};
    end
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  // monitor
  initial begin
    logic [1:0] cur;
    logic       first_half;
    int         run, lastv, ones;
    logic       fp, fpn, fm;
    cur = '0; first_half = 1'b0; run = 0; lastv = -1; ones = 0;
    push_chips(NCH);

    repeat (5) @(negedge clk);
    chk(pn_chip == SEED[11], "R1 pn_chip", pn_chip, SEED[11]);
    chk(chip_phase == 1'b0, "R1 chip_phase", chip_phase, 0);
    chk(mcode == 1'b0, "R1 mcode", mcode, 0);
    chk(seq_start == 1'b0, "R1 seq_start", seq_start, 0);

    rst = 1'b0;
    repeat (10) begin
      @(negedge clk);
      chk(pn_chip == SEED[11] && chip_phase == 1'b0 && mcode == 1'b0,
          "R1 idle after reset", {pn_chip, chip_phase, mcode}, 0);
    end

    en = 1'b1;
    for (int j = 0; j < NCH * 2 * HD; j++) begin
      int h;
      bit exp_s;
      h = j / HD;
      if (j % HD == 0) cur = exp_q.pop_front();
      if (j % HD == 0 || j % HD == HD - 1)
        chk(chip_phase == h[0], "R2 phase timing", chip_phase, h[0]);
      if (j % HD == HD / 2) begin
        chk(pn_chip == cur[1], "R3 chip value", pn_chip, cur[1]);
        chk(mcode == cur[0], "R4 coded value", mcode, cur[0]);
        if (h[0] == 1'b0) first_half = mcode;
        else chk(mcode != first_half, "R4 halves opposite", mcode, ~first_half);
        if (int'(mcode) == lastv) run++;
        else run = 1;
        lastv = int'(mcode);
        chk(run <= 2, "R6 run length", run, 2);
        if (h[0] == 1'b0 && (h / 2) < PER) ones += int'(pn_chip);
      end
      exp_s = (j == PER * 2 * HD) || (j == 2 * PER * 2 * HD);
      chk(seq_start == exp_s, "R7 start pulse", seq_start, exp_s);

      if (j == PAUSE) begin
        fp = chip_phase; fpn = pn_chip; fm = mcode;
        en = 1'b0;
        repeat (7) begin
          @(negedge clk);
          chk(chip_phase == fp && pn_chip == fpn && mcode == fm,
              "R8 frozen", {pn_chip, chip_phase, mcode}, {fpn, fp, fm});
        end
        en = 1'b1;
      end
      @(negedge clk);
    end
    chk(ones == 2048, "R5 ones per period", ones, 2048);

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule